// File: doc/BRIEF.md
# Single-Source Interrupt Gate

This block decides when one peripheral's interrupt request becomes a subroutine call on the CPU. It holds a small control register with an enable bit and a request flag. It also holds the global master enable, which software writes and a return-from-interrupt strobe sets. The CPU supplies a stack-full indication and an instruction-boundary strobe.

When a boundary strobe arrives and every condition holds, the block accepts the interrupt. Acceptance produces a one-cycle call pulse that carries the fixed vector address. At the same time the block clears the request flag and the master enable, so that no further interrupt is taken until the handler returns. A request that arrives while the stack is full stays pending and is taken at the first boundary where the stack has room.

Top module: `irq_gate`

## Requirements
- R1: After reset, `ctl_rdata` is 0, `mst_en` is 0, `call_stb` is 0 and `call_vec` is 0.
- R2: Control register layout: bit 1 is the interrupt enable and bit 5 is the request flag. A write loads both bits from `ctl_wdata`. All other bits always read 0, and writes to them are ignored.
- R3: A `req_pulse` sets the request flag at the next edge. The pulse wins over a simultaneous control write of 0 to the flag and over a simultaneous acceptance.
- R4: An interrupt is accepted only at an edge where all of these hold: `insn_bnd` is high, the master enable is 1, `stk_full` is 0, the enable bit is 1 and the request flag is 1. Without a boundary strobe, no call is ever issued.
- R5: An acceptance drives `call_stb` high for exactly the one cycle after the accepting edge. `call_vec` is 0x014 while `call_stb` is high and 0 at all other times.
- R6: At an accepting edge, the request flag is cleared (unless R3 applies) and the master enable is cleared. Clearing the master enable takes precedence over `ret_stb` and `mst_wr`.
- R7: `ret_stb` sets the master enable at the next edge and takes precedence over a simultaneous `mst_wr`.
- R8: While `stk_full` is high, a pending request is neither accepted nor lost. It is accepted at the first later boundary where the stack has room.
- R9: `mst_wr` loads `mst_wdata` into the master enable when neither an acceptance nor `ret_stb` occurs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| mst_wr | input | 1 | Master enable write strobe |
| mst_wdata | input | 1 | Master enable write value |
| mst_en | output | 1 | Current master enable |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| req_pulse | input | 1 | One-cycle request from the peripheral |
| insn_bnd | input | 1 | Instruction boundary strobe |
| stk_full | input | 1 | Call stack has no free entry |
| call_stb | output | 1 | One-cycle call request |
| call_vec | output | 12 | Call target, valid with `call_stb` |

## Verification
Every state update becomes visible one edge after its stimulus. The flag and enable bits appear on `ctl_rdata`, the master enable on `mst_en`, and an acceptance on `call_stb` and `call_vec` in the cycle that follows the accepting edge. The bench drives inputs just after a falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge against a model that it advances once per step. Directed sequences cover these cases:
- a request held over a full stack;
- a pulse colliding with a software clear;
- a return colliding with an acceptance.

Seeded random traffic fills in the rest.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int REG_W    = 8,
  parameter int EN_BIT   = 1,
  parameter int FLAG_BIT = 5,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 12'h014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [REG_W-1:0]  ctl_wdata,
  output logic [REG_W-1:0]  ctl_rdata,
  input  logic              mst_wr,
  input  logic              mst_wdata,
  output logic              mst_en,
  input  logic              ret_stb,
  input  logic              req_pulse,
  input  logic              insn_bnd,
  input  logic              stk_full,
  output logic              call_stb,
  output logic [ADDR_W-1:0] call_vec
);

  logic en_q, flag_q, me_q, call_q;

  wire take = insn_bnd && me_q && !stk_full && en_q && flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      me_q   <= 1'b0;
      call_q <= 1'b0;
    end else begin
      call_q <= take;
      if (ctl_wr) en_q <= ctl_wdata[EN_BIT];
      if (req_pulse)   flag_q <= 1'b1;
      else if (take)   flag_q <= 1'b0;
      else if (ctl_wr) flag_q <= ctl_wdata[FLAG_BIT];
      if (take)         me_q <= 1'b0;
      else if (ret_stb) me_q <= 1'b1;
      else if (mst_wr)  me_q <= mst_wdata;
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[EN_BIT]   = en_q;
    ctl_rdata[FLAG_BIT] = flag_q;
  end

  assign mst_en   = me_q;
  assign call_stb = call_q;
  assign call_vec = call_q ? VEC_ADDR : '0;

  AST_CALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    call_stb |=> !call_stb); // R5
  AST_CALL_NEEDS_BND: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_bnd || stk_full) |=> !call_stb); // R4
  AST_CALL_CLEARS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    call_stb |-> !mst_en); // R6
  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> ctl_rdata[FLAG_BIT]); // R3
  AST_RET_SETS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    ret_stb |=> (mst_en || call_stb)); // R7
  AST_FULL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && !ctl_wr && ctl_rdata[FLAG_BIT]) |=> ctl_rdata[FLAG_BIT]); // R8

endmodule

// File: tb/irq_gate_bench.sv
module irq_gate_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic ctl_wr = 0, mst_wr = 0, mst_wdata = 0, ret_stb = 0, req_pulse = 0, insn_bnd = 0, stk_full = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] ctl_rdata;
  logic mst_en, call_stb;
  logic [11:0] call_vec;

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_en, m_flag, m_me, m_call;

  always #5 clk = ~clk;

  irq_gate u_irq_gate (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mst_wr(mst_wr), .mst_wdata(mst_wdata), .mst_en(mst_en),
    .ret_stb(ret_stb), .req_pulse(req_pulse), .insn_bnd(insn_bnd), .stk_full(stk_full),
    .call_stb(call_stb), .call_vec(call_vec));

  function automatic logic [7:0] exp_rd(bit en, bit fl);
    logic [7:0] r = 8'h00;
    r[1] = en;
    r[5] = fl;
    return r;
  endfunction

  function automatic logic [11:0] exp_vec(bit c);
    return c ? 12'h014 : 12'h000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 ctl_rdata", {24'h0, ctl_rdata}, {24'h0, exp_rd(m_en, m_flag)});
    chk("R6 R7 R9 mst_en", {31'h0, mst_en}, {31'h0, m_me});
    chk("R4 R8 call_stb", {31'h0, call_stb}, {31'h0, m_call});
    chk("R5 call_vec", {20'h0, call_vec}, {20'h0, exp_vec(m_call)});
  endtask

  task automatic step(bit cw, logic [7:0] cd, bit mw, bit md, bit rt, bit rq, bit bd, bit sf);
    bit take, n_en, n_flag, n_me;
    ctl_wr = cw; ctl_wdata = cd; mst_wr = mw; mst_wdata = md;
    ret_stb = rt; req_pulse = rq; insn_bnd = bd; stk_full = sf;
    take = bd && m_me && !sf && m_en && m_flag;
    n_en = cw ? cd[1] : m_en;
    n_flag = rq ? 1'b1 : take ? 1'b0 : cw ? cd[5] : m_flag;
    n_me = take ? 1'b0 : rt ? 1'b1 : mw ? md : m_me;
    @(negedge clk);
    m_en = n_en; m_flag = n_flag; m_me = n_me; m_call = take;
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_flag = 0; m_me = 0; m_call = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ctl_rdata", {24'h0, ctl_rdata}, 32'h0);
    chk("R1 reset mst_en", {31'h0, mst_en}, 32'h0);
    chk("R1 reset call_stb", {31'h0, call_stb}, 32'h0);
    chk("R1 reset call_vec", {20'h0, call_vec}, 32'h0);
    rst_n = 1;

    // R2: other bits ignored
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    chk("R2 only bits 1 and 5", {24'h0, ctl_rdata}, 32'h22);
    step(1, 8'h02, 1, 1, 0, 0, 0, 0);
    // R3: pulse beats a software clear of the flag
    step(1, 8'h02, 0, 0, 0, 1, 0, 0);
    chk("R3 pulse over write 0", {31'h0, ctl_rdata[5]}, 32'h1);
    // R8: held while the stack is full
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R8 pending while full", {31'h0, ctl_rdata[5]}, 32'h1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 no call without boundary", {31'h0, call_stb}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 accepted after room", {31'h0, call_stb}, 32'h1);
    chk("R5 vector", {20'h0, call_vec}, 32'h014);
    chk("R6 master cleared", {31'h0, mst_en}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 single cycle", {31'h0, call_stb}, 32'h0);
    // R7: return restores master enable
    step(0, 0, 1, 0, 1, 0, 0, 0);
    chk("R7 return sets master", {31'h0, mst_en}, 32'h1);
    // R6: acceptance beats return; R3 pulse beats acceptance clear
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1, 1, 0);
    chk("R6 accept over return", {31'h0, mst_en}, 32'h0);
    chk("R3 pulse over accept", {31'h0, ctl_rdata[5]}, 32'h1);
    // R9: software write of master
    step(0, 0, 1, 1, 0, 0, 0, 0);
    chk("R9 write master", {31'h0, mst_en}, 32'h1);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R9 clear master", {31'h0, mst_en}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) == 0, 8'($urandom), ($urandom % 12) == 0, 1'($urandom),
           ($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule